// File: doc/BRIEF.md
# ADC Conversion Step Sequencer

This block drives one analog-to-digital converter core through lists of conversion steps. Each sequence is a list of step words held in a configuration bus. A step either routes one channel to the converter's positive input with the negative input on ground, routes the on-die temperature sensor in the same way, or routes an even/odd channel pair to both inputs at once as a differential measurement. Every step takes the same slot: a sample-and-hold window followed by the conversion window. A differential step therefore costs no more time than a single-ended one.

Several sequences of different lengths share the core. A one-cycle trigger marks a sequence pending. A free core picks the pending sequence with the smallest priority value and runs it to completion before it looks at the others. Each captured result is tagged with its sequence number and written to a result FIFO. A step can ask for an interrupt pulse when its result is captured. The analog core is modelled by a result-valid strobe and a data bus.

Top module: `adc_step_sequencer`

## Requirements
- R1: After reset all channel selects, the ground and temperature selects and both strobes are low, the FIFO is empty, and the overflow, selection-error and interrupt outputs are low.
- R2: In the step's slot, `sampleHold` is high for the first 4 cycles and `convert` for the next 12. The result is captured at the clock edge that ends the 16th cycle if `resValid` is high. Otherwise the step holds its last cycle until `resValid` is high. After a capture, the next step's first sample cycle follows at once.
- R3: A single-ended step (diff bit 0, temp bit 0) with channel c below NUM_CH drives `posSel` one-hot at bit c, `negSel` zero and `negGnd` high. Odd channels behave the same as even ones.
- R4: A differential step (diff bit 1, temp bit 0) with pair index N below NUM_CH/2 drives `posSel` bit 2N and `negSel` bit 2N+1 in the same slot, with `negGnd` low.
- R5: A step with the temp bit set drives `tempSel` and `negGnd` high and no channel select, whatever the other bits hold.
- R6: A channel or pair index out of range drives no select and no ground. `selErr` rises in the cycle after the step's first cycle and stays high until reset.
- R7: Step word layout, 8 bits per step, with step k of sequence s at bit offset (s*MAX_STEPS+k)*8: bit 7 end-of-sequence, bit 6 interrupt enable, bit 5 differential, bit 4 temperature, bits 3:0 channel or pair index.
- R8: A sequence ends after capturing the result of a step with the end bit set. If no step before it has the end bit, it ends after its last physical step. Sequence depths are MAX_STEPS for sequence 0, 1 for the last sequence and MAX_STEPS/2 for the others.
- R9: A trigger marks a sequence pending from the next edge. When the core is idle, the pending sequence with the smallest priority value starts on the next edge, and ties go to the lower sequence number. One idle cycle separates sequences. A trigger for a running sequence queues another run.
- R10: Each captured result enters the FIFO as {sequence number, data}, with the sequence number in the top bits. `fifoDout` shows the oldest entry. `fifoPop` removes that entry when the FIFO is not empty.
- R11: A captured step with the interrupt bit set raises the bit of its sequence in `irq` for exactly one cycle, in the cycle after the capture.
- R12: A result captured while the FIFO holds FIFO_DEPTH entries is dropped, even if a pop happens in the same cycle. `ovf` then rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig | input | NUM_SEQ | One-cycle start requests, one bit per sequence |
| seqPrio | input | NUM_SEQ*PRIO_W | Priority value per sequence, lower runs first |
| stepCfg | input | NUM_SEQ*MAX_STEPS*8 | Step words for all sequences |
| resValid | input | 1 | Converter result ready |
| resData | input | RES_W | Converter result |
| fifoPop | input | 1 | Remove the oldest FIFO entry |
| posSel | output | NUM_CH | One-hot select to the positive input |
| negSel | output | NUM_CH | One-hot select to the negative input |
| negGnd | output | 1 | Negative input tied to ground |
| tempSel | output | 1 | Temperature sensor to the positive input |
| sampleHold | output | 1 | Sample window active |
| convert | output | 1 | Conversion window active |
| fifoDout | output | SEQ_W+RES_W | Oldest result with its sequence tag |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH entries |
| irq | output | NUM_SEQ | Per-sequence interrupt pulse |
| ovf | output | 1 | Sticky result-dropped flag |
| selErr | output | 1 | Sticky out-of-range select flag |

## Verification
The hardest state to reach is an overflow that lines up with other activity. A result must arrive while the FIFO is full, and the same stimulus should also show tie-broken arbitration and a stalled conversion slot. The bench triggers all four sequences at once with no pops, so eleven results meet an eight-entry FIFO. Later it withholds `resValid` on most cycles and pops at an unrelated rate while two equal-priority sequences and a re-trigger compete. A behavioural queue model checks every output on every cycle across both phases.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int CH_FIELD_W = 4;

  typedef struct packed {
    logic                  diff;
    logic                  temp;
    logic [CH_FIELD_W-1:0] chan;
  } selCfg_t;

  typedef struct packed {
    logic    eos;
    logic    ie;
    selCfg_t sel;
  } stepCfg_t;

  localparam int CFG_W = $bits(stepCfg_t);

  typedef struct packed {
    logic    active;
    logic    sample;
    logic    convert;
    logic    first;
    logic    push;
    selCfg_t sel;
  } ctrlStrb_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_SEQ     = 4,
  parameter int MAX_STEPS   = 8,
  parameter int PRIO_W      = 2,
  parameter int SAMPLE_CLKS = 4,
  parameter int CONV_CLKS   = 12,
  localparam int SEQ_W      = $clog2(NUM_SEQ)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SEQ-1:0]               trig,
  input  logic [NUM_SEQ*PRIO_W-1:0]        prioFlat,
  input  logic [NUM_SEQ*MAX_STEPS*CFG_W-1:0] cfgFlat,
  input  logic                             resValid,
  output ctrlStrb_t                        strb,
  output logic [SEQ_W-1:0]                 curSeq,
  output logic [NUM_SEQ-1:0]               irq
);
  localparam int STEP_W = $clog2(MAX_STEPS);
  localparam int CNT_W  = $clog2(SAMPLE_CLKS + CONV_CLKS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_CLKS + CONV_CLKS - 1);
  localparam logic [CNT_W-1:0] SH_END   = CNT_W'(SAMPLE_CLKS);

  function automatic int seqDepth(input int s);
    return (s == 0) ? MAX_STEPS : ((s == NUM_SEQ - 1) ? 1 : MAX_STEPS / 2);
  endfunction

  logic              busyR;
  logic [SEQ_W-1:0]  seqR;
  logic [STEP_W-1:0] stepR;
  logic [CNT_W-1:0]  cntR;
  logic [NUM_SEQ-1:0] pending, irqR, pickMask;
  logic [SEQ_W-1:0]  pick;
  logic              pickValid;
  logic [PRIO_W-1:0] best;
  stepCfg_t          curCfg;
  logic              endSlot, capture, lastStep;

  // lowest priority value wins; strict compare keeps the lower index on ties
  always_comb begin
    pick      = '0;
    pickValid = 1'b0;
    best      = '1;
    for (int s = 0; s < NUM_SEQ; s++) begin
      if (pending[s] && (!pickValid || prioFlat[s*PRIO_W +: PRIO_W] < best)) begin
        pickValid = 1'b1;
        best      = prioFlat[s*PRIO_W +: PRIO_W];
        pick      = SEQ_W'(s);
      end
    end
  end

  always_comb begin
    int base;
    base   = (int'(seqR) * MAX_STEPS + int'(stepR)) * CFG_W;
    curCfg = stepCfg_t'(cfgFlat[base +: CFG_W]);
  end

  assign pickMask = (!busyR && pickValid) ? (NUM_SEQ'(1) << pick) : '0;
  assign endSlot  = busyR && (cntR == LAST_CNT);
  assign capture  = endSlot && resValid;
  assign lastStep = curCfg.eos || (int'(stepR) == seqDepth(int'(seqR)) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR   <= 1'b0;
      seqR    <= '0;
      stepR   <= '0;
      cntR    <= '0;
      pending <= '0;
      irqR    <= '0;
    end else begin
      irqR    <= '0;
      pending <= (pending & ~pickMask) | trig;
      if (busyR) begin
        if (capture) begin
          if (curCfg.ie) irqR[seqR] <= 1'b1;
          if (lastStep) begin
            busyR <= 1'b0;
          end else begin
            stepR <= stepR + STEP_W'(1);
            cntR  <= '0;
          end
        end else if (!endSlot) begin
          cntR <= cntR + CNT_W'(1);
        end
      end else if (pickValid) begin
        busyR <= 1'b1;
        seqR  <= pick;
        stepR <= '0;
        cntR  <= '0;
      end
    end
  end

  assign strb.active  = busyR;
  assign strb.sample  = busyR && (cntR < SH_END);
  assign strb.convert = busyR && (cntR >= SH_END);
  assign strb.first   = busyR && (cntR == '0);
  assign strb.push    = capture;
  assign strb.sel     = curCfg.sel;
  assign curSeq       = seqR;
  assign irq          = irqR;
endmodule

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int RES_W      = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int SEQ_W      = 2,
  localparam int ENT_W     = SEQ_W + RES_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [SEQ_W-1:0]  curSeq,
  input  logic [RES_W-1:0]  resData,
  input  logic              fifoPop,
  output logic [NUM_CH-1:0] posSel,
  output logic [NUM_CH-1:0] negSel,
  output logic              negGnd,
  output logic              tempSel,
  output logic              sampleHold,
  output logic              convert,
  output logic [ENT_W-1:0]  fifoDout,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              ovf,
  output logic              selErr
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [PTR_W:0]   CNT_FULL = (PTR_W + 1)'(FIFO_DEPTH);

  logic badSel;

  // front-end select decode for the current step
  always_comb begin
    posSel  = '0;
    negSel  = '0;
    negGnd  = 1'b0;
    tempSel = 1'b0;
    badSel  = 1'b0;
    if (strb.active) begin
      if (strb.sel.temp) begin
        tempSel = 1'b1;
        negGnd  = 1'b1;
      end else if (strb.sel.diff) begin
        if (int'(strb.sel.chan) < NUM_CH / 2) begin
          posSel = NUM_CH'(1) << {strb.sel.chan, 1'b0};
          negSel = NUM_CH'(2) << {strb.sel.chan, 1'b0};
        end else begin
          badSel = 1'b1;
        end
      end else if (int'(strb.sel.chan) < NUM_CH) begin
        posSel = NUM_CH'(1) << strb.sel.chan;
        negGnd = 1'b1;
      end else begin
        badSel = 1'b1;
      end
    end
  end

  assign sampleHold = strb.sample;
  assign convert    = strb.convert;

  logic [ENT_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   cnt;
  logic             doPush, doPop;

  assign fifoEmpty = (cnt == '0);
  assign fifoFull  = (cnt == CNT_FULL);
  assign doPush    = strb.push && !fifoFull;
  assign doPop     = fifoPop && !fifoEmpty;
  assign fifoDout  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {curSeq, resData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
      selErr <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + (PTR_W + 1)'(1);
        2'b01:   cnt <= cnt - (PTR_W + 1)'(1);
        default: cnt <= cnt;
      endcase
      if (strb.push && fifoFull) ovf <= 1'b1;
      if (strb.first && badSel)  selErr <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
  import adcseq_pkg::*;
#(
  parameter int NUM_SEQ     = 4,
  parameter int MAX_STEPS   = 8,
  parameter int NUM_CH      = 8,
  parameter int PRIO_W      = 2,
  parameter int RES_W       = 12,
  parameter int FIFO_DEPTH  = 8,
  parameter int SAMPLE_CLKS = 4,
  parameter int CONV_CLKS   = 12,
  localparam int SEQ_W      = $clog2(NUM_SEQ)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_SEQ-1:0]                 trig,
  input  logic [NUM_SEQ*PRIO_W-1:0]          seqPrio,
  input  logic [NUM_SEQ*MAX_STEPS*CFG_W-1:0] stepCfg,
  input  logic                               resValid,
  input  logic [RES_W-1:0]                   resData,
  input  logic                               fifoPop,
  output logic [NUM_CH-1:0]                  posSel,
  output logic [NUM_CH-1:0]                  negSel,
  output logic                               negGnd,
  output logic                               tempSel,
  output logic                               sampleHold,
  output logic                               convert,
  output logic [SEQ_W+RES_W-1:0]             fifoDout,
  output logic                               fifoEmpty,
  output logic                               fifoFull,
  output logic [NUM_SEQ-1:0]                 irq,
  output logic                               ovf,
  output logic                               selErr
);
  ctrlStrb_t        strb;
  logic [SEQ_W-1:0] curSeq;

  adcseq_ctrl #(
    .NUM_SEQ(NUM_SEQ), .MAX_STEPS(MAX_STEPS), .PRIO_W(PRIO_W),
    .SAMPLE_CLKS(SAMPLE_CLKS), .CONV_CLKS(CONV_CLKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .trig(trig), .prioFlat(seqPrio), .cfgFlat(stepCfg),
    .resValid(resValid), .strb(strb), .curSeq(curSeq), .irq(irq)
  );

  adcseq_dpath #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .FIFO_DEPTH(FIFO_DEPTH), .SEQ_W(SEQ_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .curSeq(curSeq), .resData(resData),
    .fifoPop(fifoPop), .posSel(posSel), .negSel(negSel), .negGnd(negGnd),
    .tempSel(tempSel), .sampleHold(sampleHold), .convert(convert),
    .fifoDout(fifoDout), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .ovf(ovf), .selErr(selErr)
  );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_SEQ = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] posSel,
  input logic [NUM_CH-1:0] negSel,
  input logic              negGnd,
  input logic              tempSel,
  input logic              sampleHold,
  input logic              convert,
  input logic              fifoEmpty,
  input logic              fifoFull,
  input logic [NUM_SEQ-1:0] irq,
  input logic              ovf,
  input logic              selErr
);
  // R3
  gnd_no_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    negGnd |-> (negSel == '0));
  // R4
  pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (negSel != '0) |-> (negSel == (posSel << 1)) && !negGnd);
  // R3
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(posSel) && $onehot0(negSel));
  // R5
  temp_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    tempSel |-> (posSel == '0) && (negSel == '0) && negGnd);
  // R2
  window_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleHold && convert));
  // R2
  conv_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convert) |-> $past(sampleHold));
  // R6
  sel_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> selErr);
  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> ovf);
  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irq));
  // R10
  fifo_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEmpty && fifoFull));
endmodule

bind adc_step_sequencer adcseq_chk #(.NUM_CH(NUM_CH), .NUM_SEQ(NUM_SEQ)) chk_i (
  .clk(clk), .rstN(rstN), .posSel(posSel), .negSel(negSel), .negGnd(negGnd),
  .tempSel(tempSel), .sampleHold(sampleHold), .convert(convert),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .irq(irq), .ovf(ovf), .selErr(selErr)
);

// File: tb/adc_step_sequencer_tb.sv
module adc_step_sequencer_tb_top;
  localparam int NSEQ = 4, NSTEP = 8, NCH = 8, DEPTH = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   trig = '0;
  logic [7:0]   seqPrio = '0;
  logic [255:0] stepCfg = '0;
  logic         resValid = 1'b0;
  logic [11:0]  resData = '0;
  logic         fifoPop = 1'b0;
  logic [7:0]   posSel, negSel;
  logic         negGnd, tempSel, sampleHold, convert;
  logic [13:0]  fifoDout;
  logic         fifoEmpty, fifoFull, ovf, selErr;
  logic [3:0]   irq;

  always #10 clk = ~clk;

  adc_step_sequencer dut_i (
    .clk(clk), .rstN(rstN), .trig(trig), .seqPrio(seqPrio), .stepCfg(stepCfg),
    .resValid(resValid), .resData(resData), .fifoPop(fifoPop),
    .posSel(posSel), .negSel(negSel), .negGnd(negGnd), .tempSel(tempSel),
    .sampleHold(sampleHold), .convert(convert), .fifoDout(fifoDout),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .irq(irq), .ovf(ovf), .selErr(selErr)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit doneF = 0, started = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7 step word: [7] end, [6] irq enable, [5] differential, [4] temperature, [3:0] channel/pair
  function automatic logic [7:0] cfgOf(input int s, input int k);
    return stepCfg[(s*NSTEP+k)*8 +: 8];
  endfunction
  function automatic int depthOf(input int s);
    return (s == 0) ? NSTEP : ((s == NSEQ-1) ? 1 : NSTEP/2);
  endfunction
  function automatic bit badOf(input logic [7:0] w);
    return !w[4] && (w[5] ? (w[3:0] >= 4) : (w[3:0] >= 8));
  endfunction

  // behavioural reference model
  bit mBusy, mOvf, mErr;
  int mSeq, mStep, mCnt;
  bit [3:0] mPend, mIrq;
  logic [13:0] mQ[$];
  bit mFull, mCap, mFound;
  int mBest, mPick;
  logic [7:0] mW;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mOvf = 0; mErr = 0; mSeq = 0; mStep = 0; mCnt = 0;
      mPend = 0; mIrq = 0; mQ.delete();
    end else begin
      mIrq = 0;
      mCap = mBusy && (mCnt == 15) && resValid;
      mFull = (mQ.size() == DEPTH);
      if (fifoPop && mQ.size() > 0) void'(mQ.pop_front());
      if (mCap) begin
        if (mFull) mOvf = 1;
        else mQ.push_back({2'(mSeq), resData});
      end
      if (mBusy) begin
        mW = cfgOf(mSeq, mStep);
        if (mCnt == 0 && badOf(mW)) mErr = 1;
        if (mCnt == 15) begin
          if (resValid) begin
            if (mW[6]) mIrq[mSeq] = 1;
            if (mW[7] || mStep == depthOf(mSeq) - 1) mBusy = 0;
            else begin mStep++; mCnt = 0; end
          end
        end else mCnt++;
      end else begin
        mFound = 0; mBest = 99; mPick = 0;
        for (int s = 0; s < NSEQ; s++)
          if (mPend[s] && int'(seqPrio[s*2 +: 2]) < mBest) begin
            mFound = 1; mBest = int'(seqPrio[s*2 +: 2]); mPick = s;
          end
        if (mFound) begin
          mPend[mPick] = 0; mBusy = 1; mSeq = mPick; mStep = 0; mCnt = 0;
        end
      end
      mPend = mPend | trig;
    end
  end

  // per-cycle comparison, away from the edge
  logic [7:0] eP, eN;
  bit eG, eT;
  always @(posedge clk) begin
    if (rstN && started) begin
      #5;
      eP = 0; eN = 0; eG = 0; eT = 0;
      if (mBusy) begin
        mW = cfgOf(mSeq, mStep);
        if (mW[4]) begin eT = 1; eG = 1; end
        else if (mW[5]) begin
          if (mW[3:0] < 4) begin eP[2*mW[3:0]] = 1; eN[2*mW[3:0]+1] = 1; end
        end else if (mW[3:0] < 8) begin eP[mW[3:0]] = 1; eG = 1; end
      end
      chk(posSel == eP, "R3 R4 R6 R7 posSel", posSel, eP);
      chk(negSel == eN, "R4 R6 negSel", negSel, eN);
      chk({negGnd, tempSel} == {eG, eT}, "R3 R5 gnd/temp", {negGnd, tempSel}, {eG, eT});
      chk({sampleHold, convert} == {mBusy && mCnt < 4, mBusy && mCnt >= 4},
          "R2 R8 R9 strobes", {sampleHold, convert}, {mBusy && mCnt < 4, mBusy && mCnt >= 4});
      chk(irq == mIrq, "R11 irq", irq, mIrq);
      chk(fifoEmpty == (mQ.size() == 0), "R10 empty", fifoEmpty, mQ.size() == 0);
      chk(fifoFull == (mQ.size() == DEPTH), "R10 R12 full", fifoFull, mQ.size() == DEPTH);
      if (mQ.size() > 0) chk(fifoDout == mQ[0], "R10 head", fifoDout, mQ[0]);
      chk(ovf == mOvf, "R12 ovf", ovf, mOvf);
      chk(selErr == mErr, "R6 selErr", selErr, mErr);
    end
  end

  task automatic tick(input int mode);
    @(negedge clk);
    cyc++;
    trig = '0;
    resData = 12'(cyc * 7 + 3);
    case (mode)
      0: begin resValid = 1; fifoPop = 0; end
      1: begin resValid = 1; fifoPop = 1; end
      default: begin resValid = (cyc % 5 == 0); fifoPop = (cyc % 3 == 0); end
    endcase
  endtask

  task automatic setStep(input int s, input int k, input bit e, input bit ie,
                         input bit d, input bit t, input int ch);
    stepCfg[(s*NSTEP+k)*8 +: 8] = {e, ie, d, t, 4'(ch)};
  endtask

  initial begin
    repeat (3) tick(0);
    #1;
    // R1 reset state
    chk({posSel, negSel, negGnd, tempSel, sampleHold, convert} == '0, "R1 selects", posSel, 0);
    chk(fifoEmpty && !fifoFull && !ovf && !selErr && irq == 0, "R1 flags",
        {fifoEmpty, fifoFull, ovf, selErr}, 4'b1000);
    // program sequences
    setStep(0, 0, 0, 0, 0, 0, 3);
    setStep(0, 1, 0, 0, 1, 0, 1);
    setStep(0, 2, 0, 1, 1, 0, 3);
    setStep(0, 3, 0, 0, 1, 1, 2);   // R5 temp overrides differential
    setStep(0, 4, 1, 1, 0, 0, 7);   // R8 end flag
    setStep(0, 5, 0, 1, 0, 0, 5);
    setStep(1, 0, 0, 0, 1, 0, 0);
    setStep(1, 1, 0, 0, 0, 0, 9);   // R6 bad channel
    setStep(1, 2, 0, 0, 1, 0, 5);   // R6 bad pair
    setStep(1, 3, 0, 1, 0, 0, 1);   // R8 last physical step
    setStep(2, 0, 1, 1, 1, 0, 2);
    setStep(2, 1, 0, 1, 0, 0, 0);
    setStep(3, 0, 0, 1, 0, 0, 6);
    seqPrio = {2'd2, 2'd1, 2'd1, 2'd0} ;  // seq3=2? order below
    seqPrio = {2'd0, 2'd1, 2'd1, 2'd2};   // R9 seq3 first, then 1, 2, 0
    rstN = 1;
    started = 1;
    tick(0);
    trig = 4'hf;
    repeat (260) tick(0);            // R12 eleven results into eight slots
    repeat (12) tick(1);             // drain
    seqPrio = 8'h55;                 // R9 equal priorities, lower index wins
    trig = 4'b0110;
    tick(2);
    repeat (40) tick(2);
    trig = 4'b0001;                  // R9 trigger while another runs
    tick(2);
    repeat (900) tick(2);
    repeat (12) tick(1);
    doneF = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneF) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule